// File: doc/BRIEF.md
# Dual-Slot Receive Frame Writer

This block takes the payload bytes of incoming Ethernet frames as a byte stream and writes each frame into one of two receive buffers. Each buffer is a slot of `SLOT_BYTES` bytes. Software arms a slot by setting its state to LOADED. The block picks an armed slot when a frame starts, with slot 0 first. It writes the payload at byte offset 8 of that slot. When the end marker arrives, the block fills short payloads with zeros up to 60 bytes and then appends the frame check sequence. It places the seven 0x55 bytes and the 0xD5 delimiter at offsets 0 to 7, records the stored length, and marks the slot PENDING.

The receive interrupt is a level. It stays high while either slot is PENDING. Software takes a frame by reading the count and buffer, then writes the slot state back to EMPTY or LOADED. The stream source looks at `rx_ready` before it starts a frame. While the block writes the tail of a frame (padding, check sequence and delimiter), `rx_ready` is low.

Top module: `rxslot_mgr`

## Requirements
- R1: Slot states are encoded as EMPTY=0, LOADED=1, PENDING=2, and all states and counts reset to 0. A software write to a slot's state or count appears on that slot's outputs one cycle later.
- R2: A frame starts with a valid byte that has `in_sof` set. It goes to slot 0 if slot 0 is LOADED, otherwise to slot 1 if slot 1 is LOADED. Otherwise no buffer write happens for that frame and no state changes. The buffer is written only in a slot that was LOADED.
- R3: Offsets 0 to 6 of the chosen slot receive 0x55, offset 7 receives 0xD5, and payload byte k is written to offset 8+k.
- R4: A payload shorter than 60 bytes is followed by zero bytes up to payload offset 59.
- R5: The check sequence follows the padded payload. It is the reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones, final inversion) over the padded payload only, written least significant byte first.
- R6: When a frame completes, the slot count becomes padded length + 12 and the slot state becomes PENDING.
- R7: If the padded length + 12 would exceed `SLOT_BYTES`, the frame is dropped. Its slot stays LOADED and its count is unchanged.
- R8: `rx_irq` is high exactly while at least one slot is PENDING. It follows software state writes.
- R9: `rx_ready` is high when at least one slot is LOADED and the block is not writing a frame tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload byte valid |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Payload byte |
| st_we | input | 2 | Per-slot state write enable |
| st_wdata | input | 2 | State value to write |
| cnt_we | input | 2 | Per-slot count write enable |
| cnt_wdata | input | CW | Count value to write |
| slot0_state | output | 2 | Slot 0 state |
| slot1_state | output | 2 | Slot 1 state |
| slot0_count | output | CW | Slot 0 stored byte count |
| slot1_count | output | CW | Slot 1 stored byte count |
| buf_we | output | 1 | Buffer write strobe |
| buf_slot | output | 1 | Slot being written |
| buf_addr | output | AW | Byte offset within slot |
| buf_wdata | output | 8 | Byte written |
| rx_ready | output | 1 | A frame may start |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
The assertions take for granted that software leaves the state of the slot being filled alone between the start marker and the moment that slot turns PENDING. Without that, the check that writes only land in an armed slot could fire on legal but unsupported traffic. They also assume frames are well formed, with an end marker following every start marker. The stimulus changes slot states only while the block is idle. It waits out each frame's tail before it touches any register or starts the next frame.

// File: rtl/rxslot_mgr.sv
module rxslot_mgr #(
  parameter int SLOT_BYTES = 2048,
  parameter int MIN_PAY    = 60,
  localparam int AW = $clog2(SLOT_BYTES),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [7:0]    in_data,
  input  logic [1:0]    st_we,
  input  logic [1:0]    st_wdata,
  input  logic [1:0]    cnt_we,
  input  logic [CW-1:0] cnt_wdata,
  output logic [1:0]    slot0_state,
  output logic [1:0]    slot1_state,
  output logic [CW-1:0] slot0_count,
  output logic [CW-1:0] slot1_count,
  output logic          buf_we,
  output logic          buf_slot,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_wdata,
  output logic          rx_ready,
  output logic          rx_irq
);
  localparam logic [1:0] LOADED  = 2'd1;
  localparam logic [1:0] PENDING = 2'd2;
  localparam int MAX_PAY = SLOT_BYTES - 12;

  typedef enum logic [2:0] {IDLE, DATA, SKIP, PAD, FCS, PRE} phase_t;

  phase_t         ph;
  logic [1:0]     st [2];
  logic [CW-1:0]  cnt [2];
  logic [CW-1:0]  len;
  logic [2:0]     idx;
  logic [31:0]    crc;
  logic           slot;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  wire            any_loaded = (st[0] == LOADED) || (st[1] == LOADED);
  wire            fresh      = (ph == IDLE);
  wire [CW-1:0]   len_b      = fresh ? '0 : len;
  wire [31:0]     crc_b      = fresh ? 32'hFFFFFFFF : crc;
  wire            slot_n     = fresh ? (st[0] != LOADED) : slot;
  wire [31:0]     fcs        = ~crc;

  assign slot0_state = st[0];
  assign slot1_state = st[1];
  assign slot0_count = cnt[0];
  assign slot1_count = cnt[1];
  assign rx_irq      = (st[0] == PENDING) || (st[1] == PENDING);
  assign rx_ready    = any_loaded && (ph == IDLE || ph == DATA || ph == SKIP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= IDLE;
      st[0]     <= '0;
      st[1]     <= '0;
      cnt[0]    <= '0;
      cnt[1]    <= '0;
      len       <= '0;
      idx       <= '0;
      crc       <= '0;
      slot      <= 1'b0;
      buf_we    <= 1'b0;
      buf_slot  <= 1'b0;
      buf_addr  <= '0;
      buf_wdata <= '0;
    end else begin
      buf_we <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        if (st_we[i])  st[i]  <= st_wdata;
        if (cnt_we[i]) cnt[i] <= cnt_wdata;
      end
      case (ph)
        IDLE, DATA: if (in_valid) begin
          if (fresh && !in_sof) begin
            ph <= IDLE;
          end else if ((fresh && !any_loaded) || len_b == CW'(MAX_PAY)) begin
            ph <= in_eof ? IDLE : SKIP;
          end else begin
            buf_we    <= 1'b1;
            buf_slot  <= slot_n;
            buf_addr  <= AW'(len_b + CW'(8));
            buf_wdata <= in_data;
            crc       <= crc_step(crc_b, in_data);
            len       <= len_b + 1'b1;
            slot      <= slot_n;
            idx       <= '0;
            ph        <= !in_eof ? DATA : ((len_b + 1'b1 < CW'(MIN_PAY)) ? PAD : FCS);
          end
        end
        SKIP: if (in_valid && in_eof) ph <= IDLE;
        PAD: begin
          buf_we    <= 1'b1;
          buf_slot  <= slot;
          buf_addr  <= AW'(len + CW'(8));
          buf_wdata <= 8'h00;
          crc       <= crc_step(crc, 8'h00);
          len       <= len + 1'b1;
          if (len == CW'(MIN_PAY - 1)) ph <= FCS;
        end
        FCS: begin
          buf_we    <= 1'b1;
          buf_slot  <= slot;
          buf_addr  <= AW'(len + CW'(8) + CW'(idx));
          buf_wdata <= 8'(fcs >> {idx[1:0], 3'b000});
          idx       <= idx + 1'b1;
          if (idx == 3'd3) begin
            idx <= '0;
            ph  <= PRE;
          end
        end
        PRE: begin
          buf_we    <= 1'b1;
          buf_slot  <= slot;
          buf_addr  <= AW'(idx);
          buf_wdata <= (idx == 3'd7) ? 8'hD5 : 8'h55;
          idx       <= idx + 1'b1;
          if (idx == 3'd7) begin
            st[slot]  <= PENDING;
            cnt[slot] <= len + CW'(12);
            ph        <= IDLE;
          end
        end
        default: ph <= IDLE;
      endcase
    end
  end
endmodule

module rxslot_mgr_chk #(
  parameter int SLOT_BYTES = 2048,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          buf_we,
  input logic          buf_slot,
  input logic [1:0]    st_we,
  input logic [1:0]    slot0_state,
  input logic [1:0]    slot1_state,
  input logic [CW-1:0] slot0_count,
  input logic          rx_ready,
  input logic          rx_irq
);
  // R2
  write_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> ((buf_slot ? $past(slot1_state) : $past(slot0_state)) == 2'd1));
  // R6
  pend_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(st_we[0]) && $past(slot0_state) == 2'd1 && slot0_state == 2'd2)
      |-> (slot0_count >= CW'(72) && slot0_count <= CW'(SLOT_BYTES)));
  // R8
  irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot0_state == 2'd2 || slot1_state == 2'd2) |-> rx_irq);
  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_irq) |-> $past(st_we) != 2'b00);
  // R9
  ready_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (slot0_state == 2'd1 || slot1_state == 2'd1));
endmodule

bind rxslot_mgr rxslot_mgr_chk #(.SLOT_BYTES(SLOT_BYTES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_slot(buf_slot), .st_we(st_we),
  .slot0_state(slot0_state), .slot1_state(slot1_state), .slot0_count(slot0_count),
  .rx_ready(rx_ready), .rx_irq(rx_irq));

// File: tb/rxslot_mgr_test.sv
module rxslot_mgr_test;
  localparam int CLK_PERIOD = 10;
  localparam int SB = 2048;
  localparam int AW = 11;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] st_we = '0, st_wdata = '0, cnt_we = '0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [1:0] s0, s1;
  logic [CW-1:0] c0, c1;
  logic buf_we, buf_slot, rx_ready, rx_irq;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_wdata;

  int checks = 0, fails = 0, wcount = 0;
  logic [7:0] mem [0:1][0:SB-1];
  logic [7:0] pay [0:SB-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  rxslot_mgr uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .st_we(st_we), .st_wdata(st_wdata), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .slot0_state(s0), .slot1_state(s1), .slot0_count(c0),
    .slot1_count(c1), .buf_we(buf_we), .buf_slot(buf_slot), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .rx_ready(rx_ready), .rx_irq(rx_irq));

  always @(negedge clk) if (buf_we) begin
    mem[buf_slot][buf_addr] = buf_wdata;
    wcount++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_state(input int slot, input logic [1:0] v);
    @(negedge clk); st_we = 2'b01 << slot; st_wdata = v;
    @(negedge clk); st_we = '0;
  endtask

  task automatic set_count(input int slot, input int v);
    @(negedge clk); cnt_we = 2'b01 << slot; cnt_wdata = CW'(v);
    @(negedge clk); cnt_we = '0;
  endtask

  task automatic send(input int n, input int seed);
    for (int s = 0; s < 2; s++) for (int a = 0; a < SB; a++) mem[s][a] = 8'hEE;
    for (int i = 0; i < n; i++) begin
      pay[i] = 8'(seed + i * 7);
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == n - 1); in_data = pay[i];
    end
    @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  task automatic check_image(input int slot, input int n, input string tag);
    int p, bad;
    logic [31:0] c;
    logic [7:0] b;
    p = (n < 60) ? 60 : n;
    bad = 0;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 8; i++)
      if (mem[slot][i] !== ((i == 7) ? 8'hD5 : 8'h55)) bad++;
    for (int i = 0; i < p; i++) begin
      b = (i < n) ? pay[i] : 8'h00;
      if (mem[slot][8 + i] !== b) bad++;
      c = c ^ {24'd0, b};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    for (int i = 0; i < 4; i++)
      if (mem[slot][8 + p + i] !== c[8*i +: 8]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic t_reset;
    chk(s0 == 2'd0 && s1 == 2'd0, "R1 reset states", {s1, s0}, 0);
    chk(c0 == 0 && c1 == 0, "R1 reset counts", c0 + c1, 0);
    chk(rx_irq == 1'b0, "R8 irq after reset", rx_irq, 0);
    chk(rx_ready == 1'b0, "R9 ready with no armed slot", rx_ready, 0);
  endtask

  task automatic t_no_slot;
    int w;
    w = wcount;
    send(20, 3);
    chk(wcount == w, "R2 frame with no LOADED slot writes nothing", wcount - w, 0);
    chk(s0 == 2'd0 && s1 == 2'd0, "R2 states unchanged", {s1, s0}, 0);
  endtask

  task automatic t_full;
    set_state(0, 2'd1);
    chk(rx_ready == 1'b1, "R9 ready once slot 0 LOADED", rx_ready, 1);
    send(64, 11);
    chk(s0 == 2'd2, "R6 slot 0 PENDING", s0, 2);
    chk(c0 == 76, "R6 count for 64-byte payload", c0, 76);
    chk(rx_irq == 1'b1, "R8 irq with slot 0 PENDING", rx_irq, 1);
    chk(rx_ready == 1'b0, "R9 ready low with none LOADED", rx_ready, 0);
    check_image(0, 64, "R3 R5 64-byte image");
  endtask

  task automatic t_priority;
    set_state(0, 2'd0);
    chk(rx_irq == 1'b0, "R8 irq drops after state write", rx_irq, 0);
    set_state(1, 2'd1);
    set_state(0, 2'd1);
    send(10, 40);
    chk(s0 == 2'd2 && c0 == 72, "R2 slot 0 first, count 72", c0, 72);
    chk(s1 == 2'd1, "R2 slot 1 untouched", s1, 1);
    check_image(0, 10, "R4 padded 10-byte image");
    send(60, 90);
    chk(s1 == 2'd2 && c1 == 72, "R2 next frame to slot 1", c1, 72);
    check_image(1, 60, "R5 60-byte image slot 1");
  endtask

  task automatic t_single;
    set_state(0, 2'd0);
    set_state(1, 2'd1);
    chk(rx_irq == 1'b0, "R8 irq low with no PENDING", rx_irq, 0);
    send(1, 200);
    chk(s1 == 2'd2 && c1 == 72, "R6 one-byte frame count", c1, 72);
    chk(rx_irq == 1'b1, "R8 irq from slot 1 alone", rx_irq, 1);
    check_image(1, 1, "R4 one-byte image");
  endtask

  task automatic t_oversize;
    set_state(1, 2'd0);
    set_count(0, 0);
    set_state(0, 2'd1);
    send(2037, 5);
    chk(s0 == 2'd1, "R7 oversize leaves slot LOADED", s0, 1);
    chk(c0 == 0, "R7 oversize count unchanged", c0, 0);
    chk(rx_irq == 1'b0, "R7 oversize raises no irq", rx_irq, 0);
    send(2036, 9);
    chk(s0 == 2'd2 && c0 == 2048, "R7 largest frame fills slot", c0, 2048);
    check_image(0, 2036, "R3 R5 full-slot image");
  endtask

  task automatic t_regs;
    set_count(1, 1234);
    chk(c1 == 1234, "R1 count write readback", c1, 1234);
    set_state(1, 2'd2);
    chk(s1 == 2'd2, "R1 state write readback", s1, 2);
    set_state(0, 2'd0);
    chk(rx_irq == 1'b1, "R8 software PENDING raises irq", rx_irq, 1);
    set_state(1, 2'd0);
    chk(rx_irq == 1'b0, "R8 irq low after clearing", rx_irq, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_no_slot;
    t_full;
    t_priority;
    t_single;
    t_oversize;
    t_regs;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule